// File: doc/BRIEF.md
# External Interrupt Input Unit

This block turns up to six asynchronous external interrupt pins into interrupt requests for a downstream interrupt controller. Each pin is brought into the clock domain by a two-flop synchroniser. It is then compared against a per-channel trigger selection: rising edge, falling edge, either edge, active-high level or active-low level. A qualifying event sets that channel's pending bit. The request line for a channel is driven when its pending bit and its enable bit are both set.

Software programs the unit over a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. There are four registers. One holds the trigger selections, with one 4-bit field per channel. One holds the pending flags, which software clears by writing zero to a bit. One holds the enable mask. The fourth is a plain scratch word. When software first brings a channel up, it normally selects active-low level triggering.

Top module: `ext_irq_unit`

## Requirements
- R1: Every pin passes through two synchronising flops. A pin change made between two clock edges is reflected in the pending register and the request output after the third rising edge that follows, and not after the second.
- R2: Trigger code 1 (rising edge) sets the pending bit on a 0-to-1 transition of the synchronised pin. The bit stays set after the pin returns low, until software clears it.
- R3: Trigger code 2 (falling edge) sets the pending bit on a 1-to-0 transition of the synchronised pin. It does not set the bit on a 0-to-1 transition.
- R4: Trigger code 3 (both edges) sets the pending bit on either transition.
- R5: Trigger code 5 (active-high level) sets the pending bit on every cycle the synchronised pin is high. A clear written while the pin is still high leaves the bit set. A clear written once the pin is low takes effect.
- R6: Trigger code 6 (active-low level) behaves like R5 with the polarity inverted.
- R7: Trigger codes 0, 4 and 7 to 15 never set the pending bit, whatever the pin does.
- R8: A write to offset 0x8 clears each pending bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged. Writing 1 never sets a pending bit.
- R9: Request output i is high exactly when pending bit i and enable bit i (offset 0xC, bit i) are both 1.
- R10: After reset, every register reads zero and every request output is low.
- R11: Offset 0x4 is a 32-bit read/write word with no effect on behaviour. Any offset other than 0x0, 0x4, 0x8 and 0xC reads zero, and writes to it change nothing.
- R12: Offset 0x0 holds channel i's trigger code in bits 4i+3 down to 4i. Bits above 4*NUM_CH-1 read zero. Pending bit i is bit i of offset 0x8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | NUM_CH (6) | Asynchronous external interrupt pins |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | NUM_CH (6) | Per-channel interrupt request |

## Verification
Register writes take effect at the rising edge on which the strobe is sampled. Read data is combinational, so the bench samples it one time unit after presenting an address, away from any edge. A pin change reaches the pending register after three rising edges: two synchroniser stages plus the pending flop. The directed latency checks sample at the falling edge after the second edge, where the old value is still expected, and again after the third edge, where the new value is expected. In the random phase a bench model advances at each rising edge with the same three-stage lag. The request outputs and read data are compared against that model at every falling edge, before new stimulus is driven.

// File: rtl/eiu_pkg.sv
package eiu_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;
    localparam int CODE_W = 4;

    localparam logic [BUS_AW-1:0] OFS_TRIG  = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_SCRAT = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_PEND  = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_MASK  = 8'h0C;

    typedef enum logic [CODE_W-1:0] {
        TRIG_OFF  = 4'd0,
        TRIG_RISE = 4'd1,
        TRIG_FALL = 4'd2,
        TRIG_BOTH = 4'd3,
        TRIG_HIGH = 4'd5,
        TRIG_LOW  = 4'd6
    } trig_e;

    typedef struct packed {
        logic on_rise;
        logic on_fall;
        logic on_high;
        logic on_low;
    } trig_sel_t;

    function automatic trig_sel_t decode_trig(input logic [CODE_W-1:0] code);
        trig_sel_t s;
        s = '0;
        case (code)
            TRIG_RISE: s.on_rise = 1'b1;
            TRIG_FALL: s.on_fall = 1'b1;
            TRIG_BOTH: begin s.on_rise = 1'b1; s.on_fall = 1'b1; end
            TRIG_HIGH: s.on_high = 1'b1;
            TRIG_LOW:  s.on_low  = 1'b1;
            default:   s = '0;
        endcase
        return s;
    endfunction

    function automatic logic trig_fires(input trig_sel_t s, input logic cur, input logic old);
        return (s.on_rise & cur & ~old) | (s.on_fall & ~cur & old) |
               (s.on_high & cur) | (s.on_low & ~cur);
    endfunction

    function automatic logic code_is_live(input logic [CODE_W-1:0] code);
        return (code == TRIG_RISE) || (code == TRIG_FALL) || (code == TRIG_BOTH) ||
               (code == TRIG_HIGH) || (code == TRIG_LOW);
    endfunction

endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pin_async,
    output logic [NUM_CH-1:0] pin_sync
);
    logic [NUM_CH-1:0] stage1_q;
    logic [NUM_CH-1:0] stage2_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1_q[i] <= 1'b0;
                stage2_q[i] <= 1'b0;
            end else begin
                stage1_q[i] <= pin_async[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign pin_sync = stage2_q;

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // two stages between pin and synchronised output (R1)
    p_sync_lag_r1: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> (pin_sync == $past(pin_async, 2)));

endmodule

// File: rtl/eiu_detect.sv
module eiu_detect
    import eiu_pkg::*;
#(
    parameter int NUM_CH = 6,
    localparam int TRIG_W = CODE_W * NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pin_sync,
    input  logic [TRIG_W-1:0] trig_cfg,
    output logic [NUM_CH-1:0] set_pend
);
    logic [NUM_CH-1:0] last_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        trig_sel_t sel;
        assign sel = decode_trig(trig_cfg[CODE_W*i +: CODE_W]);

        always_ff @(posedge clk) begin
            if (rst) last_q[i] <= 1'b0;
            else     last_q[i] <= pin_sync[i];
        end

        assign set_pend[i] = trig_fires(sel, pin_sync[i], last_q[i]);
    end

endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
    import eiu_pkg::*;
#(
    parameter int NUM_CH = 6,
    localparam int TRIG_W = CODE_W * NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] set_pend,
    output logic [TRIG_W-1:0] trig_cfg,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] irq_o
);
    logic [TRIG_W-1:0] trig_q;
    logic [BUS_DW-1:0] scrat_q;
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] keep_mask;

    logic wr_trig, wr_scrat, wr_pend, wr_mask;
    assign wr_trig  = bus_wr && (bus_addr == OFS_TRIG);
    assign wr_scrat = bus_wr && (bus_addr == OFS_SCRAT);
    assign wr_pend  = bus_wr && (bus_addr == OFS_PEND);
    assign wr_mask  = bus_wr && (bus_addr == OFS_MASK);

    assign keep_mask = wr_pend ? bus_wdata[NUM_CH-1:0] : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q  <= '0;
            scrat_q <= '0;
            pend_q  <= '0;
            mask_q  <= '0;
        end else begin
            if (wr_trig)  trig_q  <= bus_wdata[TRIG_W-1:0];
            if (wr_scrat) scrat_q <= bus_wdata;
            if (wr_mask)  mask_q  <= bus_wdata[NUM_CH-1:0];
            pend_q <= (pend_q & keep_mask) | set_pend;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_TRIG:  bus_rdata[TRIG_W-1:0] = trig_q;
            OFS_SCRAT: bus_rdata = scrat_q;
            OFS_PEND:  bus_rdata[NUM_CH-1:0] = pend_q;
            OFS_MASK:  bus_rdata[NUM_CH-1:0] = mask_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign trig_cfg = trig_q;
    assign irq_o    = pend_q & mask_q;

    // a detected event is captured in pending on the next edge (R2)
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (set_pend != '0) |=> ((pend_q & $past(set_pend)) == $past(set_pend)));

    // zero-written bits without a new event are cleared (R8)
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        wr_pend |=> ((pend_q & ~$past(bus_wdata[NUM_CH-1:0]) & ~$past(set_pend)) == '0));

    // without an event or a pending write, pending holds (R8)
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!wr_pend && set_pend == '0) |=> (pend_q == $past(pend_q)));

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
    import eiu_pkg::*;
#(
    parameter int NUM_CH = 6,
    localparam int TRIG_W = CODE_W * NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ext_in,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_o
);
    logic [NUM_CH-1:0] pin_sync;
    logic [NUM_CH-1:0] set_pend;
    logic [TRIG_W-1:0] trig_cfg;
    logic [NUM_CH-1:0] mask_q;

    eiu_sync #(.NUM_CH(NUM_CH)) u_sync (
        .clk(clk), .rst(rst), .pin_async(ext_in), .pin_sync(pin_sync)
    );

    eiu_detect #(.NUM_CH(NUM_CH)) u_detect (
        .clk(clk), .rst(rst), .pin_sync(pin_sync), .trig_cfg(trig_cfg),
        .set_pend(set_pend)
    );

    eiu_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .set_pend(set_pend),
        .trig_cfg(trig_cfg), .mask_q(mask_q), .irq_o(irq_o)
    );

    // a masked channel never requests (R9)
    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ((irq_o & ~mask_q) == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // reserved or off codes never raise an event (R7)
        p_reserved_r7: assert property (@(posedge clk) disable iff (rst)
            !code_is_live(trig_cfg[CODE_W*i +: CODE_W]) |-> !set_pend[i]);
    end

endmodule

// File: tb/tb_ext_irq_unit.sv
module tb_ext_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;
    localparam int WATCHDOG = 200000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    ext_in = '0;
    logic [7:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    ext_irq_unit #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst(rst), .ext_in(ext_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model built from the requirements
    logic [NCH-1:0] m_s1, m_s2, m_old, m_pend, m_mask;
    logic [4*NCH-1:0] m_trig;
    logic [31:0] m_scrat;

    function automatic logic ref_fire(input logic [3:0] code, input logic cur, input logic old);
        case (code)
            4'd1: return cur & ~old;
            4'd2: return ~cur & old;
            4'd3: return cur ^ old;
            4'd5: return cur;
            4'd6: return ~cur;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] ref_read(input logic [7:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            8'h00: r[4*NCH-1:0] = m_trig;
            8'h04: r = m_scrat;
            8'h08: r[NCH-1:0] = m_pend;
            8'h0C: r[NCH-1:0] = m_mask;
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_old <= '0; m_pend <= '0;
            m_mask <= '0; m_trig <= '0; m_scrat <= '0;
        end else begin
            logic [NCH-1:0] nxt;
            m_s1 <= ext_in;
            m_s2 <= m_s1;
            m_old <= m_s2;
            nxt = m_pend;
            if (bus_wr && bus_addr == 8'h08) nxt = nxt & bus_wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++)
                if (ref_fire(m_trig[4*i +: 4], m_s2[i], m_old[i])) nxt[i] = 1'b1;
            m_pend <= nxt;
            if (bus_wr && bus_addr == 8'h00) m_trig <= bus_wdata[4*NCH-1:0];
            if (bus_wr && bus_addr == 8'h04) m_scrat <= bus_wdata;
            if (bus_wr && bus_addr == 8'h0C) m_mask <= bus_wdata[NCH-1:0];
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4711));
        tick(3);
        rst = 1'b0;
        tick(1);

        // R10: reset state
        bus_read(8'h00, d); check("R10 trig", d, 32'h0);
        bus_read(8'h04, d); check("R10 scratch", d, 32'h0);
        bus_read(8'h08, d); check("R10 pend", d, 32'h0);
        bus_read(8'h0C, d); check("R10 mask", d, 32'h0);
        check("R10 irq", 32'(irq_o), 32'h0);

        // R12: field layout, upper bits read zero
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, d); check("R12 trig width", d, 32'h00FF_FFFF);
        bus_write(8'h00, 32'h0065_4321);
        bus_read(8'h00, d); check("R12 trig fields", d, 32'h0065_4321);
        bus_write(8'h00, 32'h0);
        bus_write(8'h08, 32'h0);

        // R11: scratch and unused offsets
        bus_write(8'h04, 32'hDEAD_BEEF);
        bus_read(8'h04, d); check("R11 scratch", d, 32'hDEAD_BEEF);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, d); check("R11 unused read", d, 32'h0);
        bus_read(8'h00, d); check("R11 unused no trig", d, 32'h0);
        bus_read(8'h0C, d); check("R11 unused no mask", d, 32'h0);

        // R1 + R2: rising edge on channel 0, latency
        bus_write(8'h00, 32'h1);
        bus_write(8'h0C, 32'h3F);
        ext_in[0] = 1'b1;
        tick(2);
        bus_read(8'h08, d); check("R1 not yet after two edges", d, 32'h0);
        tick(1);
        bus_read(8'h08, d); check("R1 pending after three edges", d, 32'h1);
        check("R9 irq follows pending", 32'(irq_o), 32'h1);
        ext_in[0] = 1'b0;
        tick(4);
        bus_read(8'h08, d); check("R2 sticky after pin low", d, 32'h1);
        bus_write(8'h08, 32'h3E);
        bus_read(8'h08, d); check("R8 clear by zero", d, 32'h0);

        // R3: falling edge
        bus_write(8'h00, 32'h2);
        ext_in[0] = 1'b1;
        tick(4);
        bus_read(8'h08, d); check("R3 no set on rise", d, 32'h0);
        ext_in[0] = 1'b0;
        tick(3);
        bus_read(8'h08, d); check("R3 set on fall", d, 32'h1);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, d); check("R8 write one keeps", d, 32'h1);
        bus_write(8'h08, 32'h0);

        // R4: both edges
        bus_write(8'h00, 32'h3);
        ext_in[0] = 1'b1;
        tick(3);
        bus_read(8'h08, d); check("R4 rise", d, 32'h1);
        bus_write(8'h08, 32'h0);
        ext_in[0] = 1'b0;
        tick(3);
        bus_read(8'h08, d); check("R4 fall", d, 32'h1);
        bus_write(8'h08, 32'h0);

        // R5: active-high level
        bus_write(8'h00, 32'h5);
        ext_in[0] = 1'b1;
        tick(3);
        bus_write(8'h08, 32'h0);
        bus_read(8'h08, d); check("R5 clear blocked while high", d, 32'h1);
        ext_in[0] = 1'b0;
        tick(3);
        bus_write(8'h08, 32'h0);
        bus_read(8'h08, d); check("R5 clear after low", d, 32'h0);

        // R6: active-low level on channel 1
        bus_write(8'h00, 32'h60);
        tick(1);
        bus_read(8'h08, d); check("R6 low sets", d, 32'h2);
        bus_write(8'h08, 32'h0);
        bus_read(8'h08, d); check("R6 clear blocked while low", d, 32'h2);
        check("R6 irq ch1", 32'(irq_o), 32'h2);
        ext_in[1] = 1'b1;
        tick(3);
        bus_write(8'h08, 32'h0);
        bus_read(8'h08, d); check("R6 clear after high", d, 32'h0);

        // R7: reserved codes on channel 2
        foreach (d[k]) begin end
        for (int c = 0; c < 16; c++) begin
            if (c == 1 || c == 2 || c == 3 || c == 5 || c == 6) continue;
            bus_write(8'h00, 32'(c) << 8);
            for (int t = 0; t < 3; t++) begin
                ext_in[2] = ~ext_in[2];
                tick(3);
            end
            bus_read(8'h08, d); check($sformatf("R7 code %0d", c), d, 32'h0);
        end
        ext_in = '0;
        bus_write(8'h00, 32'h0);
        tick(3);
        bus_write(8'h08, 32'h0);

        // R9: mask gating
        bus_write(8'h0C, 32'h0);
        bus_write(8'h00, 32'h1);
        ext_in[0] = 1'b1;
        tick(3);
        bus_read(8'h08, d); check("R9 pending while masked", d, 32'h1);
        check("R9 masked irq low", 32'(irq_o), 32'h0);
        bus_write(8'h0C, 32'h1);
        check("R9 unmasked irq high", 32'(irq_o), 32'h1);

        // random phase compared against the model
        for (int cyc = 0; cyc < 4000; cyc++) begin
            logic [7:0] a;
            bus_read(bus_addr, d);
            check("R9 random irq", 32'(irq_o), 32'(m_pend & m_mask));
            check("R2-R8 random read", d, ref_read(bus_addr));
            ext_in = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : ext_in;
            case ($urandom_range(0, 4))
                0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
                default: a = 8'h10;
            endcase
            bus_addr = a;
            bus_wdata = $urandom;
            bus_wr = ($urandom_range(0, 7) == 0);
            @(negedge clk);
        end
        bus_wr = 1'b0;
        finish_run();
    end
endmodule